// File: doc/BRIEF.md
# T3/E3 Receive Error Event Counters

This block sits behind a T3/E3 receive framer and keeps two 16-bit performance counts that a host reads. The framer reports, once per frame, a strobe with the F-bit and M-bit error counts, the number of bit errors in the frame alignment word, a flag for a frame alignment word that contains any error, the two received parity bits and the parity it computed over the information bits. It also reports a loss-of-frame level. The block does not align frames.

The framing counter is configured by a line-mode input (T3 or E3) and a 2-bit event select. It counts either loss-of-frame occurrences or one of several classes of framing errors. The parity counter counts T3 parity errors. A gating input decides whether error counting goes on while the frame is lost. A one-cycle latch strobe copies both live counts into holding registers and starts a new counting period. The host reads the held values one byte at a time.

Top module: `pm_err_counters`

## Requirements
- R1: After reset both holding registers and both live counts are zero, so every byte read returns 0x00.
- R2: With select 00 the framing counter adds one on every cycle where loss-of-frame is high and was low in the previous cycle (taken as low right after reset), in either mode. It needs no frame strobe, ignores the gating input, and does not count further while loss-of-frame stays high.
- R3: In T3 mode with select 01, each cycle with the frame strobe high adds the F-bit error count plus the M-bit error count. Cycles without the strobe add nothing to either counter, except as stated in R2.
- R4: In T3 mode select 10 adds only the F-bit error count per strobe, and select 11 adds only the M-bit error count.
- R5: In E3 mode select 01 adds the alignment-word bit-error count per strobe, and select 10 adds one per strobe that carries the alignment-word error flag.
- R6: In E3 mode select 11 is illegal and the framing counter does not change.
- R7: When the gating input is 0 and loss-of-frame is high, strobes add nothing for selects 01, 10 and 11 and nothing to the parity counter. When the gating input is 1, counting goes on during loss-of-frame.
- R8: In T3 mode each strobe adds one to the parity counter when the two received parity bits differ from each other, or when they agree with each other but differ from the computed parity.
- R9: In E3 mode the parity counter never changes.
- R10: Both counters saturate at 0xFFFF and never wrap.
- R11: A latch strobe copies both live counts into the holding registers. The live counts then restart at the amount that events in that same cycle add.
- R12: The read data is the held value byte selected by rd_sel: 0 = framing low byte, 1 = framing high byte, 2 = parity low byte, 3 = parity high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_e3 | input | 1 | Line mode: 0 = T3, 1 = E3 |
| evt_sel | input | 2 | Framing counter event select |
| cnt_in_lof | input | 1 | 1 = keep counting errors during loss-of-frame |
| lof | input | 1 | Loss-of-frame level from the framer |
| frm_stb | input | 1 | Per-frame strobe qualifying the error inputs |
| f_errs | input | 5 | F-bit errors in this frame |
| m_errs | input | 5 | M-bit errors in this frame |
| fas_bit_errs | input | 4 | Bit errors in the E3 frame alignment word |
| fas_word_err | input | 1 | E3 alignment word had at least one error |
| par_rx | input | 2 | The two received parity bits |
| par_calc | input | 1 | Locally computed parity |
| latch | input | 1 | Copy live counts to holding registers and start a new period |
| rd_sel | input | 2 | Byte select for rd_data |
| rd_data | output | 8 | Selected byte of the held counts |

## Verification
The assertions assume the configuration inputs hold still for at least one cycle while their effect is checked. They also assume the internal reset is used as the disable condition, so the cycles of reset synchronisation are excluded. The stimulus changes mode, select and gating only at segment boundaries, right after a latch, and it keeps the error counts within the widths a real framer can report. Loss-of-frame toggles at random within a segment so that edges, long high stretches and the gated cases all occur.

// File: rtl/pm_pkg.sv
package pm_pkg;

  typedef enum logic [1:0] {
    SEL_LOF_EDGE = 2'b00,
    SEL_BOTH     = 2'b01,
    SEL_FIRST    = 2'b10,
    SEL_SECOND   = 2'b11
  } evt_sel_t;

endpackage

// File: rtl/pm_rst_sync.sv
module pm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];

endmodule

// File: rtl/pm_event_sel.sv
module pm_event_sel
  import pm_pkg::*;
#(
  parameter int ERR_W = 5,
  parameter int FAS_W = 4,
  parameter int INC_W = 6
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             mode_e3,
  input  logic [1:0]       evt_sel,
  input  logic             cnt_in_lof,
  input  logic             lof,
  input  logic             frm_stb,
  input  logic [ERR_W-1:0] f_errs,
  input  logic [ERR_W-1:0] m_errs,
  input  logic [FAS_W-1:0] fas_bit_errs,
  input  logic             fas_word_err,
  input  logic [1:0]       par_rx,
  input  logic             par_calc,
  output logic [INC_W-1:0] frm_inc,
  output logic             par_inc,
  output logic             lof_d1
);

  logic lof_q;
  logic lof_q_nx;
  logic lof_rise;
  logic err_ok;
  logic par_bad;

  // next state of the loss-of-frame history
  always_comb begin
    lof_q_nx = lof;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) lof_q <= 1'b0;
    else         lof_q <= lof_q_nx;
  end

  assign lof_d1   = lof_q;
  assign lof_rise = lof & ~lof_q;
  assign err_ok   = frm_stb & (~lof | cnt_in_lof);
  assign par_bad  = (par_rx[0] ^ par_rx[1]) | (par_rx[0] ^ par_calc);

  always_comb begin
    frm_inc = '0;
    unique case (evt_sel_t'(evt_sel))
      SEL_LOF_EDGE: frm_inc = INC_W'(lof_rise);
      SEL_BOTH: begin
        if (err_ok) begin
          if (mode_e3) frm_inc = INC_W'(fas_bit_errs);
          else         frm_inc = INC_W'(f_errs) + INC_W'(m_errs);
        end
      end
      SEL_FIRST: begin
        if (err_ok) begin
          if (mode_e3) frm_inc = INC_W'(fas_word_err);
          else         frm_inc = INC_W'(f_errs);
        end
      end
      SEL_SECOND: begin
        if (err_ok && !mode_e3) frm_inc = INC_W'(m_errs);
      end
      default: frm_inc = '0;
    endcase
  end

  assign par_inc = err_ok & ~mode_e3 & par_bad;

endmodule

// File: rtl/pm_sat_cnt.sv
module pm_sat_cnt #(
  parameter int CW    = 16,
  parameter int INC_W = 6
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             clr,
  input  logic [INC_W-1:0] inc,
  output logic [CW-1:0]    cnt
);

  localparam logic [CW:0] MAX_EXT = {1'b0, {CW{1'b1}}};

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nx;
  logic [CW:0]   base;
  logic [CW:0]   sum;
  logic          cnt_en;

  always_comb begin
    base   = clr ? '0 : {1'b0, cnt_q};
    sum    = base + (CW + 1)'(inc);
    cnt_nx = (sum > MAX_EXT) ? MAX_EXT[CW-1:0] : sum[CW-1:0];
    cnt_en = clr | (|inc);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nx;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/pm_snap.sv
module pm_snap #(
  parameter int CW    = 16,
  parameter int NCNT  = 2,
  parameter int SEL_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_sn,
  input  logic                 latch,
  input  logic [NCNT*CW-1:0]   live,
  input  logic [SEL_W-1:0]     rd_sel,
  output logic [NCNT*CW-1:0]   held,
  output logic [7:0]           rd_data
);

  localparam int OFF_W = SEL_W + 3;

  logic [NCNT*CW-1:0] held_q;
  logic [NCNT*CW-1:0] held_nx;
  logic [OFF_W-1:0]   offs;

  always_comb begin
    held_nx = live;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)    held_q <= '0;
    else if (latch) held_q <= held_nx;
  end

  assign offs    = {rd_sel, 3'b000};
  assign rd_data = held_q[offs +: 8];
  assign held    = held_q;

endmodule

// File: rtl/pm_err_counters.sv
module pm_err_counters
  import pm_pkg::*;
#(
  parameter int CW    = 16,
  parameter int ERR_W = 5,
  parameter int FAS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_e3,
  input  logic [1:0]       evt_sel,
  input  logic             cnt_in_lof,
  input  logic             lof,
  input  logic             frm_stb,
  input  logic [ERR_W-1:0] f_errs,
  input  logic [ERR_W-1:0] m_errs,
  input  logic [FAS_W-1:0] fas_bit_errs,
  input  logic             fas_word_err,
  input  logic [1:0]       par_rx,
  input  logic             par_calc,
  input  logic             latch,
  input  logic [1:0]       rd_sel,
  output logic [7:0]       rd_data
);

  localparam int NCNT  = 2;
  localparam int INC_W = (ERR_W + 1 > FAS_W) ? ERR_W + 1 : FAS_W;
  localparam int SEL_W = $clog2(NCNT * CW / 8);

  logic                       rst_sn;
  logic [INC_W-1:0]           frm_inc;
  logic                       par_inc;
  logic                       lof_d1;
  logic [NCNT-1:0][INC_W-1:0] inc_v;
  logic [NCNT*CW-1:0]         live_flat;
  logic [NCNT*CW-1:0]         held_flat;
  logic [CW-1:0]              frm_live;
  logic [CW-1:0]              par_live;
  logic [CW-1:0]              frm_hold;
  logic [CW-1:0]              par_hold;

  pm_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  pm_event_sel #(.ERR_W(ERR_W), .FAS_W(FAS_W), .INC_W(INC_W)) u_sel (
    .clk          (clk),
    .rst_sn       (rst_sn),
    .mode_e3      (mode_e3),
    .evt_sel      (evt_sel),
    .cnt_in_lof   (cnt_in_lof),
    .lof          (lof),
    .frm_stb      (frm_stb),
    .f_errs       (f_errs),
    .m_errs       (m_errs),
    .fas_bit_errs (fas_bit_errs),
    .fas_word_err (fas_word_err),
    .par_rx       (par_rx),
    .par_calc     (par_calc),
    .frm_inc      (frm_inc),
    .par_inc      (par_inc),
    .lof_d1       (lof_d1)
  );

  assign inc_v[0] = frm_inc;
  assign inc_v[1] = INC_W'(par_inc);

  for (genvar gi = 0; gi < NCNT; gi++) begin : g_cnt
    pm_sat_cnt #(.CW(CW), .INC_W(INC_W)) u_cnt (
      .clk    (clk),
      .rst_sn (rst_sn),
      .clr    (latch),
      .inc    (inc_v[gi]),
      .cnt    (live_flat[gi*CW +: CW])
    );
  end

  pm_snap #(.CW(CW), .NCNT(NCNT), .SEL_W(SEL_W)) u_snap (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .latch   (latch),
    .live    (live_flat),
    .rd_sel  (SEL_W'(rd_sel)),
    .held    (held_flat),
    .rd_data (rd_data)
  );

  assign frm_live = live_flat[0 +: CW];
  assign par_live = live_flat[CW +: CW];
  assign frm_hold = held_flat[0 +: CW];
  assign par_hold = held_flat[CW +: CW];

endmodule

// File: rtl/pm_err_chk.sv
module pm_err_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_sn,
  input logic          mode_e3,
  input logic [1:0]    evt_sel,
  input logic          cnt_in_lof,
  input logic          lof,
  input logic          lof_d1,
  input logic          frm_stb,
  input logic          latch,
  input logic [CW-1:0] frm_live,
  input logic [CW-1:0] par_live,
  input logic [CW-1:0] frm_hold,
  input logic [CW-1:0] par_hold
);

  // R2
  lof_level_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!latch && evt_sel == 2'b00 && !(lof && !lof_d1)) |=> $stable(frm_live));

  // R3
  no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!latch && !frm_stb) |=> $stable(par_live));

  // R6
  e3_illegal_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!latch && mode_e3 && evt_sel == 2'b11) |=> $stable(frm_live));

  // R7
  lof_gate_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!latch && !cnt_in_lof && lof && evt_sel != 2'b00) |=> $stable(frm_live));

  // R7
  lof_gate_par_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!latch && !cnt_in_lof && lof) |=> $stable(par_live));

  // R9
  e3_parity_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!latch && mode_e3) |=> $stable(par_live));

  // R10
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !latch |=> (frm_live >= $past(frm_live) && par_live >= $past(par_live)));

  // R11
  latch_copy_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    latch |=> (frm_hold == $past(frm_live) && par_hold == $past(par_live)));

  // R11
  hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !latch |=> ($stable(frm_hold) && $stable(par_hold)));

endmodule

bind pm_err_counters pm_err_chk #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_sn     (rst_sn),
  .mode_e3    (mode_e3),
  .evt_sel    (evt_sel),
  .cnt_in_lof (cnt_in_lof),
  .lof        (lof),
  .lof_d1     (lof_d1),
  .frm_stb    (frm_stb),
  .latch      (latch),
  .frm_live   (frm_live),
  .par_live   (par_live),
  .frm_hold   (frm_hold),
  .par_hold   (par_hold)
);

// File: tb/tb_pm_err_counters.sv
module tb_pm_err_counters;

  localparam int CLK_PER = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_e3, cnt_in_lof, lof, frm_stb, fas_word_err, par_calc, latch;
  logic [1:0] evt_sel, par_rx, rd_sel;
  logic [4:0] f_errs, m_errs;
  logic [3:0] fas_bit_errs;
  logic [7:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;

  // bench model state
  int unsigned m_frm, m_par, m_frm_h, m_par_h;
  logic        m_lofq;

  pm_err_counters dut (
    .clk(clk), .rst_n(rst_n), .mode_e3(mode_e3), .evt_sel(evt_sel),
    .cnt_in_lof(cnt_in_lof), .lof(lof), .frm_stb(frm_stb), .f_errs(f_errs),
    .m_errs(m_errs), .fas_bit_errs(fas_bit_errs), .fas_word_err(fas_word_err),
    .par_rx(par_rx), .par_calc(par_calc), .latch(latch), .rd_sel(rd_sel),
    .rd_data(rd_data)
  );

  always #(CLK_PER/2) clk = ~clk;

  function automatic int unsigned sat16(int unsigned v);
    return (v > 32'hFFFF) ? 32'hFFFF : v;
  endfunction

  function automatic int unsigned frm_amount();
    logic ok;
    ok = frm_stb && (!lof || cnt_in_lof);
    if (evt_sel == 2'b00) return (lof && !m_lofq) ? 1 : 0;
    if (!ok) return 0;
    if (!mode_e3) begin
      case (evt_sel)
        2'b01:   return int'(f_errs) + int'(m_errs);
        2'b10:   return int'(f_errs);
        default: return int'(m_errs);
      endcase
    end
    case (evt_sel)
      2'b01:   return int'(fas_bit_errs);
      2'b10:   return fas_word_err ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned par_amount();
    logic bad;
    bad = (par_rx[0] != par_rx[1]) || (par_rx[0] != par_calc);
    return (!mode_e3 && frm_stb && (!lof || cnt_in_lof) && bad) ? 1 : 0;
  endfunction

  task automatic tick();
    int unsigned fi, pi;
    fi = frm_amount();
    pi = par_amount();
    m_lofq = lof;
    if (latch) begin
      m_frm_h = m_frm; m_par_h = m_par;
      m_frm = sat16(fi); m_par = sat16(pi);
    end else begin
      m_frm = sat16(m_frm + fi); m_par = sat16(m_par + pi);
    end
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, int unsigned act, int unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // read all held bytes (R12) and compare with the model
  task automatic check_held(string tag);
    logic [7:0] b0, b1, b2, b3;
    rd_sel = 2'd0; #1 b0 = rd_data;
    rd_sel = 2'd1; #1 b1 = rd_data;
    rd_sel = 2'd2; #1 b2 = rd_data;
    rd_sel = 2'd3; #1 b3 = rd_data;
    chk({tag, "/R12 framing"}, {b1, b0}, m_frm_h);
    chk({tag, "/R12 parity"},  {b3, b2}, m_par_h);
  endtask

  task automatic idle();
    frm_stb = 0; f_errs = 0; m_errs = 0; fas_bit_errs = 0; fas_word_err = 0;
    par_rx = 0; par_calc = 0; latch = 0;
  endtask

  task automatic do_latch(string tag);
    idle(); latch = 1; tick(); latch = 0;
    check_held(tag);
  endtask

  task automatic set_cfg(logic e3, logic [1:0] s, logic g);
    mode_e3 = e3; evt_sel = s; cnt_in_lof = g;
  endtask

  function automatic string tag_of();
    if (evt_sel == 2'b00) return "R2";
    if (mode_e3 && evt_sel == 2'b11) return "R6";
    if (mode_e3) return "R5";
    if (evt_sel == 2'b01) return "R3";
    return "R4";
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; idle(); lof = 0; rd_sel = 0;
    set_cfg(1'b0, 2'b01, 1'b0);
    m_frm = 0; m_par = 0; m_frm_h = 0; m_par_h = 0; m_lofq = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    check_held("R1");

    // R2: level high for many cycles counts once; E3 too; gating ignored
    set_cfg(1'b1, 2'b00, 1'b0);
    idle(); lof = 1; repeat (5) tick();
    lof = 0; tick(); lof = 1; tick(); lof = 0; tick();
    do_latch("R2 edges");

    // R8: parity cases in T3
    set_cfg(1'b0, 2'b10, 1'b0);
    idle(); frm_stb = 1;
    par_rx = 2'b01; par_calc = 0; tick();
    par_rx = 2'b11; par_calc = 0; tick();
    par_rx = 2'b00; par_calc = 0; tick();
    par_rx = 2'b11; par_calc = 1; tick();
    do_latch("R8");

    // R9: parity errors in E3 not counted; R6 illegal select
    set_cfg(1'b1, 2'b11, 1'b1);
    idle(); frm_stb = 1; par_rx = 2'b01; fas_bit_errs = 4'd7; fas_word_err = 1;
    repeat (6) tick();
    do_latch("R9/R6");

    // R7: gated during loss-of-frame, then allowed
    set_cfg(1'b0, 2'b01, 1'b0);
    idle(); lof = 1; frm_stb = 1; f_errs = 5'd3; m_errs = 5'd2; par_rx = 2'b10;
    repeat (4) tick();
    do_latch("R7 gated");
    set_cfg(1'b0, 2'b01, 1'b1);
    idle(); lof = 1; frm_stb = 1; f_errs = 5'd3; m_errs = 5'd2; par_rx = 2'b10;
    repeat (4) tick();
    lof = 0;
    do_latch("R7 open");

    // R11: event in the latch cycle goes into the new period
    set_cfg(1'b0, 2'b10, 1'b0);
    idle(); frm_stb = 1; f_errs = 5'd9; tick();
    f_errs = 5'd4; par_rx = 2'b01; latch = 1; tick();
    check_held("R11 latch-cycle");
    do_latch("R11 new period");

    // R10: saturation with the largest per-frame sums
    set_cfg(1'b0, 2'b01, 1'b1);
    idle(); frm_stb = 1; f_errs = 5'd31; m_errs = 5'd31; par_rx = 2'b01;
    repeat (1100) tick();
    do_latch("R10 framing");
    idle(); frm_stb = 1; par_rx = 2'b01;
    repeat (65600) tick();
    do_latch("R10 parity");

    // random segments
    for (int seg = 0; seg < 48; seg++) begin
      set_cfg(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
              1'($urandom_range(0, 1)));
      for (int k = 0; k < 60; k++) begin
        frm_stb      = ($urandom_range(0, 3) != 0);
        f_errs       = 5'($urandom_range(0, 6));
        m_errs       = 5'($urandom_range(0, 3));
        fas_bit_errs = 4'($urandom_range(0, 10));
        fas_word_err = 1'($urandom_range(0, 1));
        par_rx       = 2'($urandom_range(0, 3));
        par_calc     = 1'($urandom_range(0, 1));
        if ($urandom_range(0, 7) == 0) lof = ~lof;
        latch        = ($urandom_range(0, 40) == 0);
        tick();
        if (latch) begin
          latch = 0;
          check_held({tag_of(), " mid"});
        end
      end
      do_latch(tag_of());
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule